// File: doc/BRIEF.md
# Two-Kind Translation Cache

This block caches address translations for a 32-bit virtual space split into 4 KB pages. One 4-way set-associative array holds two kinds of records: leaf records, which map a full 20-bit virtual page number to a physical frame, and directory records, which cache the first-level pointer selected by the top 10 bits of the page number. Every stored record carries a kind flag. When a page walker misses on a leaf, it can still find the directory record and skip the first level of its walk.

Both lookup paths are combinational reads of the current contents. A walker writes records through the fill port, and each write takes effect at the next clock edge. A flush invalidates, in one cycle, every record whose global bit is clear. Replacement fills a free way first and otherwise rotates through the ways of each set.

Top module: `tlb_dir_cache`

## Requirements
- R1: After reset every record is invalid: both lookups miss, and every data output (frame, attributes, physical address, directory record) reads zero.
- R2: A leaf fill of page number V with record E is visible from the cycle after the fill edge. A leaf lookup of V then hits, with frame = E[31:12] and attributes = E[11:0]. The set is V[3:0] and the tag is V[19:4].
- R3: On a leaf hit the physical address output is the cached frame above the 12-bit offset input. On a miss it is zero.
- R4: A directory fill keys the record by the top 10 bits of the supplied page number, zero-extended to 20 bits. A directory lookup with those 10 bits returns the record.
- R5: A lookup only matches records of its own kind. A leaf record and a directory record with the same 20-bit key coexist, and each lookup returns its own one.
- R6: A fill whose key is absent goes to the lowest-numbered invalid way of its set.
- R7: When all four ways of the set are valid, a fill takes the way named by that set's rotation pointer. The pointer is zero after reset and steps by one (mod 4) on each such fill only.
- R8: A fill whose key and kind already sit in the set overwrites that way in place. No duplicate is created and the rotation pointer does not move.
- R9: A flush pulse invalidates, at one edge, every record whose bit 8 (global) is clear. Records with bit 8 set stay valid and unchanged.
- R10: When a flush and a fill share a cycle, the way is chosen from the contents before the flush, and the filled record is valid afterwards.
- R11: A lookup in the same cycle as a fill of its key sees the old contents.
- R12: A fill changes only its own set. Records in other sets keep hitting with their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 20 | Virtual page number for leaf lookup |
| lk_off | input | 12 | Page offset joined to the frame on a hit |
| lk_hit | output | 1 | Leaf lookup hit |
| lk_ppn | output | 20 | Cached physical frame number (zero on miss) |
| lk_attr | output | 12 | Low 12 bits of the cached record (zero on miss) |
| lk_paddr | output | 32 | Physical address (zero on miss) |
| dl_idx | input | 10 | Top page-number bits for directory lookup |
| dl_hit | output | 1 | Directory lookup hit |
| dl_entry | output | 32 | Cached directory record (zero on miss) |
| fill_en | input | 1 | Write a record at the next edge |
| fill_dir | input | 1 | Fill kind: 1 directory, 0 leaf |
| fill_vpn | input | 20 | Page number of the record being filled |
| fill_entry | input | 32 | Record contents |
| flush | input | 1 | Invalidate all non-global records |

## Verification
The bench aims at keys that share a set and a tag but differ in kind. A design that ignores the kind flag would return a leaf frame on a directory lookup, or the reverse. It fills one set past its capacity and then refills a resident key. Wrong rotation or a missing in-place match shows up as the wrong record being evicted, or as a duplicate hit. Flushes are issued with global and non-global records mixed, with and without a fill in the same cycle. A design that flushes everything, or picks the victim after the flush, loses different records than the model expects. A lookup that shares a cycle with a fill of its own key must still miss; an RTL that bypasses write data into the read path would hit there.

// File: rtl/tlb_dir_pkg.sv
package tlb_dir_pkg;
  // Kind of record held in a way
  typedef enum logic {
    KIND_LEAF = 1'b0,
    KIND_DIR  = 1'b1
  } tlb_kind_e;
endpackage

// File: rtl/tlb_way_match.sv
// Compares one set's ways against a tag and a record kind.
module tlb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int ENT_W = 32
) (
  input  logic [WAYS-1:0]             way_v,
  input  logic [WAYS-1:0]             way_dir,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0][ENT_W-1:0]  way_ent,
  input  tlb_dir_pkg::tlb_kind_e      want,
  input  logic [TAG_W-1:0]            key_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [$clog2(WAYS)-1:0]     hit_way,
  output logic [ENT_W-1:0]            hit_ent
);
  localparam int WAY_W = $clog2(WAYS);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_v[g] & (way_dir[g] == logic'(want)) &
                        (way_tag[g] == key_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    hit_ent = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_way = WAY_W'(i);
        hit_ent = way_ent[i];
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
// Chooses the way a fill writes: resident match, then free way, then rotation.
module tlb_victim #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]          way_v,
  input  logic [$clog2(WAYS)-1:0]  rr_ptr,
  input  logic                     match_hit,
  input  logic [$clog2(WAYS)-1:0]  match_way,
  output logic [$clog2(WAYS)-1:0]  vic_way,
  output logic                     vic_rr
);
  localparam int WAY_W = $clog2(WAYS);

  logic free_any;
  logic [WAY_W-1:0] free_way;

  assign free_any = ~&way_v;

  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_v[i]) free_way = WAY_W'(i);
    end
  end

  always_comb begin
    vic_rr = 1'b0;
    if (match_hit) begin
      vic_way = match_way;
    end else if (free_any) begin
      vic_way = free_way;
    end else begin
      vic_way = rr_ptr;
      vic_rr  = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_dir_cache.sv
// Set-associative translation cache holding leaf and directory records.
module tlb_dir_cache #(
  parameter int VPN_W      = 20,
  parameter int OFF_W      = 12,
  parameter int DIR_W      = 10,
  parameter int SET_W      = 4,
  parameter int WAYS       = 4,
  parameter int ENT_W      = 32,
  parameter int GLOBAL_BIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [OFF_W-1:0]         lk_off,
  output logic                     lk_hit,
  output logic [ENT_W-OFF_W-1:0]   lk_ppn,
  output logic [OFF_W-1:0]         lk_attr,
  output logic [ENT_W-1:0]         lk_paddr,
  input  logic [DIR_W-1:0]         dl_idx,
  output logic                     dl_hit,
  output logic [ENT_W-1:0]         dl_entry,
  input  logic                     fill_en,
  input  logic                     fill_dir,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [ENT_W-1:0]         fill_entry,
  input  logic                     flush
);
  import tlb_dir_pkg::*;

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  // Storage
  logic [SETS-1:0][WAYS-1:0]             val_q, val_n;
  logic [SETS-1:0][WAYS-1:0]             dir_q, dir_n;
  logic [SETS-1:0][WAYS-1:0]             glob_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q, tag_n;
  logic [SETS-1:0][WAYS-1:0][ENT_W-1:0]  ent_q, ent_n;
  logic [SETS-1:0][WAY_W-1:0]            rr_q, rr_n;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign glob_q[s][w] = ent_q[s][w][GLOBAL_BIT];
    end
  end

  // Key formation
  logic [VPN_W-1:0] dl_key, fill_key;
  logic [SET_W-1:0] lk_set, dl_set, f_set;
  assign dl_key   = VPN_W'(dl_idx);
  assign fill_key = fill_dir ? VPN_W'(fill_vpn[VPN_W-1 -: DIR_W]) : fill_vpn;
  assign lk_set   = lk_vpn[SET_W-1:0];
  assign dl_set   = dl_key[SET_W-1:0];
  assign f_set    = fill_key[SET_W-1:0];

  tlb_kind_e fill_kind;
  assign fill_kind = fill_dir ? KIND_DIR : KIND_LEAF;

  // Lookups
  logic [WAYS-1:0]  lk_hvec, dl_hvec, f_hvec;
  logic [WAY_W-1:0] lk_way, dl_way, f_mway, f_way;
  logic [ENT_W-1:0] lk_ent, f_ent;
  logic             f_hit, f_rr;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_lk_match (
    .way_v(val_q[lk_set]), .way_dir(dir_q[lk_set]), .way_tag(tag_q[lk_set]),
    .way_ent(ent_q[lk_set]), .want(KIND_LEAF), .key_tag(lk_vpn[VPN_W-1:SET_W]),
    .hit_vec(lk_hvec), .hit(lk_hit), .hit_way(lk_way), .hit_ent(lk_ent)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_dl_match (
    .way_v(val_q[dl_set]), .way_dir(dir_q[dl_set]), .way_tag(tag_q[dl_set]),
    .way_ent(ent_q[dl_set]), .want(KIND_DIR), .key_tag(dl_key[VPN_W-1:SET_W]),
    .hit_vec(dl_hvec), .hit(dl_hit), .hit_way(dl_way), .hit_ent(dl_entry)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_fill_match (
    .way_v(val_q[f_set]), .way_dir(dir_q[f_set]), .way_tag(tag_q[f_set]),
    .way_ent(ent_q[f_set]), .want(fill_kind), .key_tag(fill_key[VPN_W-1:SET_W]),
    .hit_vec(f_hvec), .hit(f_hit), .hit_way(f_mway), .hit_ent(f_ent)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .way_v(val_q[f_set]), .rr_ptr(rr_q[f_set]), .match_hit(f_hit),
    .match_way(f_mway), .vic_way(f_way), .vic_rr(f_rr)
  );

  assign lk_ppn   = lk_ent[ENT_W-1:OFF_W];
  assign lk_attr  = lk_ent[OFF_W-1:0];
  assign lk_paddr = lk_hit ? {lk_ppn, lk_off} : '0;

  // Next state: flush first, then the fill on top
  always_comb begin
    val_n = val_q;
    dir_n = dir_q;
    tag_n = tag_q;
    ent_n = ent_q;
    rr_n  = rr_q;
    if (flush) val_n = val_q & glob_q;
    if (fill_en) begin
      val_n[f_set][f_way] = 1'b1;
      dir_n[f_set][f_way] = fill_dir;
      tag_n[f_set][f_way] = fill_key[VPN_W-1:SET_W];
      ent_n[f_set][f_way] = fill_entry;
      if (f_rr) rr_n[f_set] = rr_q[f_set] + 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dir_q <= '0;
      rr_q  <= '0;
    end else begin
      if (flush || fill_en) val_q <= val_n;
      if (fill_en) begin
        dir_q <= dir_n;
        rr_q  <= rr_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q <= tag_n;
      ent_q <= ent_n;
    end
  end

  // Assertions
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> val_q[$past(f_set)][$past(f_way)]);  // R2
  AST_KIND_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !dir_q[lk_set][lk_way]);  // R5
  AST_DIR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    dl_hit |-> dir_q[dl_set][dl_way]);  // R5
  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !f_hit && !(&val_q[f_set])) |-> !val_q[f_set][f_way]);  // R6
  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && f_rr) |=> rr_q[$past(f_set)] == WAY_W'($past(rr_q[f_set]) + 1'b1));  // R7
  AST_ONE_LEAF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hvec));  // R8
  AST_ONE_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dl_hvec));  // R8
  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fill_en) |=> ((val_q & ~glob_q) == '0));  // R9
endmodule

// File: tb/tlb_dir_cache_bench.sv
module tlb_dir_cache_bench;
  localparam int SETS = 16;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] lk_vpn;
  logic [11:0] lk_off;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [11:0] lk_attr;
  logic [31:0] lk_paddr;
  logic [9:0]  dl_idx;
  logic        dl_hit;
  logic [31:0] dl_entry;
  logic        fill_en, fill_dir, flush;
  logic [19:0] fill_vpn;
  logic [31:0] fill_entry;

  always #2 clk = ~clk;

  tlb_dir_cache u_tlb_dir_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_attr(lk_attr), .lk_paddr(lk_paddr),
    .dl_idx(dl_idx), .dl_hit(dl_hit), .dl_entry(dl_entry),
    .fill_en(fill_en), .fill_dir(fill_dir), .fill_vpn(fill_vpn),
    .fill_entry(fill_entry), .flush(flush)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Behavioural model
  bit          m_v  [SETS][WAYS];
  bit          m_d  [SETS][WAYS];
  int unsigned m_tag[SETS][WAYS];
  logic [31:0] m_ent[SETS][WAYS];
  int          m_rr [SETS];

  function automatic int m_find(int s, int unsigned t, bit d);
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_d[s][w] == d && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare all outputs at mid-cycle, then advance the model across the edge
  task automatic cyc(string req);
    int w, s, fw;
    int unsigned t;
    logic [19:0] key;
    logic [31:0] e;
    bit use_rr;
    #1;
    s = int'(lk_vpn[3:0]); t = lk_vpn[19:4];
    w = m_find(s, t, 1'b0);
    e = (w >= 0) ? m_ent[s][w] : 32'h0;
    check(lk_hit == (w >= 0), req, "leaf hit", {31'h0, lk_hit}, {31'h0, w >= 0});
    check(lk_ppn == e[31:12], req, "frame", {12'h0, lk_ppn}, {12'h0, e[31:12]});
    check(lk_attr == e[11:0], req, "attr", {20'h0, lk_attr}, {20'h0, e[11:0]});
    check(lk_paddr == ((w >= 0) ? {e[31:12], lk_off} : 32'h0), req, "paddr",
          lk_paddr, (w >= 0) ? {e[31:12], lk_off} : 32'h0);
    key = {10'h0, dl_idx};
    s = int'(key[3:0]); t = key[19:4];
    w = m_find(s, t, 1'b1);
    e = (w >= 0) ? m_ent[s][w] : 32'h0;
    check(dl_hit == (w >= 0), req, "dir hit", {31'h0, dl_hit}, {31'h0, w >= 0});
    check(dl_entry == e, req, "dir entry", dl_entry, e);
    if (rst_n) begin
      fw = -1; use_rr = 1'b0; s = 0; t = 0;
      if (fill_en) begin
        key = fill_dir ? {10'h0, fill_vpn[19:10]} : fill_vpn;
        s = int'(key[3:0]); t = key[19:4];
        fw = m_find(s, t, fill_dir);
        if (fw < 0)
          for (int k = WAYS - 1; k >= 0; k--) if (!m_v[s][k]) fw = k;
        if (fw < 0) begin fw = m_rr[s]; use_rr = 1'b1; end
      end
      if (flush)
        for (int a = 0; a < SETS; a++)
          for (int b = 0; b < WAYS; b++)
            if (!m_ent[a][b][8]) m_v[a][b] = 1'b0;
      if (fill_en) begin
        m_v[s][fw] = 1'b1; m_d[s][fw] = fill_dir;
        m_tag[s][fw] = t;  m_ent[s][fw] = fill_entry;
        if (use_rr) m_rr[s] = (m_rr[s] + 1) % WAYS;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic drive(bit fe, bit fd, logic [19:0] fv, logic [31:0] fent, bit fl,
                       logic [19:0] lv, logic [11:0] lo, logic [9:0] di, string req);
    fill_en = fe; fill_dir = fd; fill_vpn = fv; fill_entry = fent; flush = fl;
    lk_vpn = lv; lk_off = lo; dl_idx = di;
    cyc(req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < SETS; a++) begin
      m_rr[a] = 0;
      for (int b = 0; b < WAYS; b++) begin
        m_v[a][b] = 0; m_d[a][b] = 0; m_tag[a][b] = 0; m_ent[a][b] = 32'h0;
      end
    end
    rst_n = 1'b0;
    fill_en = 0; fill_dir = 0; fill_vpn = '0; fill_entry = '0; flush = 0;
    lk_vpn = '0; lk_off = '0; dl_idx = '0;
    @(posedge clk); #1;
    drive(0, 0, 0, 0, 0, 20'h00000, 12'h000, 10'h000, "R1");
    drive(0, 0, 0, 0, 0, 20'hABCD5, 12'h123, 10'h2AF, "R1");
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 20'h00000, 12'h000, 10'h000, "R1");

    // R2 / R3: leaf fill then lookup
    drive(1, 0, 20'hABCD5, 32'h76543103, 0, 20'h00000, 12'h0, 10'h0, "R2");
    drive(0, 0, 0, 0, 0, 20'hABCD5, 12'h9A5, 10'h0, "R3");
    drive(0, 0, 0, 0, 0, 20'hABCD6, 12'h9A5, 10'h0, "R2");

    // R11: fill and lookup of the same key in one cycle
    drive(1, 0, 20'h11115, 32'h22222044, 0, 20'h11115, 12'h777, 10'h0, "R11");
    drive(0, 0, 0, 0, 0, 20'h11115, 12'h777, 10'h0, "R11");

    // R4 / R5: directory record, same key as a later leaf record
    drive(1, 1, 20'h12345, 32'hCAFE0007, 0, 20'h0, 12'h0, 10'h048, "R4");
    drive(0, 0, 0, 0, 0, 20'h00048, 12'h001, 10'h048, "R5");
    drive(1, 0, 20'h00048, 32'h0BEEF005, 0, 20'h00048, 12'h0, 10'h048, "R5");
    drive(0, 0, 0, 0, 0, 20'h00048, 12'h002, 10'h048, "R5");

    // R6 / R7: overfill set 3, alternating global bit
    for (int n = 1; n <= 7; n++) begin
      drive(1, 0, {16'(n), 4'h3}, {20'(n * 16'h111), 3'b000, n[0], 8'h01}, 0,
            {16'(n), 4'h3}, 12'h0, 10'h003, "R6");
      for (int q = 1; q <= n; q++)
        drive(0, 0, 0, 0, 0, {16'(q), 4'h3}, 12'h0AB, 10'h003, "R7");
    end

    // R8: refill a resident key
    drive(1, 0, 20'h00073, 32'h99999F01, 0, 20'h00073, 12'h0, 10'h0, "R8");
    for (int q = 1; q <= 7; q++)
      drive(0, 0, 0, 0, 0, {16'(q), 4'h3}, 12'h0CD, 10'h0, "R8");
    drive(1, 0, 20'h00083, 32'h88888001, 0, 20'h00083, 12'h0, 10'h0, "R7");
    for (int q = 1; q <= 8; q++)
      drive(0, 0, 0, 0, 0, {16'(q), 4'h3}, 12'h0CD, 10'h0, "R7");

    // R12: fill elsewhere, earlier set-5 record survives
    drive(1, 0, 20'h55556, 32'h44444000, 0, 20'hABCD5, 12'h0, 10'h048, "R12");
    drive(0, 0, 0, 0, 0, 20'hABCD5, 12'h010, 10'h048, "R12");

    // R9: flush keeps only global records
    drive(0, 0, 0, 0, 1, 20'h0, 12'h0, 10'h0, "R9");
    for (int q = 1; q <= 8; q++)
      drive(0, 0, 0, 0, 0, {16'(q), 4'h3}, 12'h0EF, 10'h048, "R9");
    drive(0, 0, 0, 0, 0, 20'hABCD5, 12'h0, 10'h048, "R9");
    drive(0, 0, 0, 0, 0, 20'h11115, 12'h0, 10'h048, "R9");

    // R10: flush with a fill in the same cycle
    drive(1, 0, 20'h00093, 32'h31415000, 0, 20'h0, 12'h0, 10'h0, "R10");
    drive(1, 0, 20'h000A3, 32'h27182000, 0, 20'h0, 12'h0, 10'h0, "R10");
    drive(1, 0, 20'h000B3, 32'h16180000, 1, 20'h0, 12'h0, 10'h0, "R10");
    for (int q = 1; q <= 11; q++)
      drive(0, 0, 0, 0, 0, {16'(q), 4'h3}, 12'h0EF, 10'h0, "R10");

    // Mixed traffic over a narrow key space
    for (int r = 0; r < 3000; r++) begin
      logic [19:0] fv, lv;
      fv = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 4'($urandom_range(0, 3))};
      lv = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 4'($urandom_range(0, 3))};
      drive(($urandom_range(0, 9) < 4), ($urandom_range(0, 9) < 3), fv,
            32'($urandom), ($urandom_range(0, 39) == 0), lv,
            12'($urandom), 10'($urandom_range(0, 3)), "R12");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule